// File: doc/BRIEF.md
# Direct-Mapped Translation Buffer with Access Permissions

This block translates virtual addresses to physical addresses for one memory port. It holds a small, directly indexed set of page translations. Each slot keeps a page tag, a physical frame number and three flags: readable, writable and present. Every load and every store presents its virtual address and its access type. In the same cycle the block returns the physical address, a hit indication and a two-bit fault code. The fault code tells a miss apart from a read violation and from a write violation.

A miss handler outside the block walks the page tables. It then installs the result through the fill port, one slot per clock edge. A single flush pulse discards every translation, for example on an address-space switch. The default configuration has eight slots, 32-bit virtual and physical addresses, and 4 KiB pages. With these defaults the slot index is VA[14:12], the tag is VA[31:15], and VA[11:0] passes through unchanged.

Top module: `xlat_tlb`

## Requirements
- R1: After an asynchronous reset (rst_ni low), every slot is not present, so every lookup reports a miss.
- R2: With the defaults, a lookup uses slot VA[14:12] and compares VA[31:15] with that slot's stored tag. A fill of virtual page number fill_vpn_i writes slot fill_vpn_i[2:0] with tag fill_vpn_i[19:3].
- R3: On a hit, lk_pa_o equals {stored frame number, lk_va_i[11:0]}, lk_hit_o is 1 and lk_fault_o is 2'b00.
- R4: If the indexed slot is not present or its tag differs, lk_fault_o is 2'b01 (miss).
- R5: A read (lk_wr_i=0) that hits a slot whose read flag is clear gives lk_fault_o 2'b10.
- R6: A write (lk_wr_i=1) that hits a slot whose write flag is clear gives lk_fault_o 2'b11. The read flag has no effect on writes, and the write flag has no effect on reads.
- R7: A miss takes priority over permission faults. An absent or mismatching slot reports 2'b01 whatever its flags are.
- R8: A fill (fill_en_i=1) updates the slot at the next rising clock edge and is visible to combinational lookups right after that edge. A fill with fill_vld_i=0 makes the slot absent.
- R9: A flush_i pulse clears all slots' present flags at one clock edge.
- R10: When flush_i and fill_en_i are high in the same cycle, the flush wins and the fill has no effect.
- R11: Whenever lk_fault_o is not 2'b00, lk_hit_o is 0 and lk_pa_o is all zeros.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| lk_va_i | input | 32 | Virtual address to translate |
| lk_wr_i | input | 1 | Access type: 1 write, 0 read |
| lk_pa_o | output | 32 | Translated physical address, zero unless hit |
| lk_hit_o | output | 1 | Translation succeeded |
| lk_fault_o | output | 2 | 00 none, 01 miss, 10 read denied, 11 write denied |
| fill_en_i | input | 1 | Write one slot at the next edge |
| fill_vpn_i | input | 20 | Virtual page number of the new translation |
| fill_pfn_i | input | 20 | Physical frame number of the new translation |
| fill_vld_i | input | 1 | Present flag to store |
| fill_rd_i | input | 1 | Read permission to store |
| fill_wr_i | input | 1 | Write permission to store |
| flush_i | input | 1 | Clear every present flag |

## Verification
The bench fills all eight slots so that they cover every combination of read and write flag. It then probes each slot with matching and mismatching tags, with both access types and with several page offsets. A design that swapped the permission flags, or compared the wrong address bits, would return the wrong fault code for some slot. Absent slots that carry both flags set are also probed. A design that checked permissions before the tag would report a permission fault or a hit where a miss is due. A flush issued in the same cycle as a fill, and a fill with the present flag cleared, are both checked. A design that let the fill through, or ignored the present bit on fill, would still hit afterwards.

// File: rtl/xtlb_pkg.sv
package xtlb_pkg;
  typedef enum logic [1:0] {
    FLT_NONE = 2'b00,
    FLT_MISS = 2'b01,
    FLT_RD   = 2'b10,
    FLT_WR   = 2'b11
  } flt_e;
endpackage

// File: rtl/xtlb_store.sv
module xtlb_store #(
  parameter int unsigned ENTRIES = 8,
  parameter int unsigned TAG_W   = 17,
  parameter int unsigned PFN_W   = 20,
  localparam int unsigned IDX_W  = $clog2(ENTRIES)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             flush_i,
  input  logic             wen_i,
  input  logic [IDX_W-1:0] widx_i,
  input  logic [TAG_W-1:0] wtag_i,
  input  logic [PFN_W-1:0] wpfn_i,
  input  logic             wvld_i,
  input  logic             wrd_i,
  input  logic             wwr_i,
  input  logic [IDX_W-1:0] ridx_i,
  output logic [TAG_W-1:0] rtag_o,
  output logic [PFN_W-1:0] rpfn_o,
  output logic             rvld_o,
  output logic             rrd_o,
  output logic             rwr_o
);
  logic [TAG_W-1:0] tag_q [ENTRIES];
  logic [PFN_W-1:0] pfn_q [ENTRIES];
  logic [ENTRIES-1:0] vld_q, rd_q, wr_q;

  for (genvar g = 0; g < ENTRIES; g++) begin : g_slot
    logic sel;
    assign sel = wen_i && !flush_i && (widx_i == IDX_W'(g));

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        vld_q[g] <= 1'b0;
        rd_q[g]  <= 1'b0;
        wr_q[g]  <= 1'b0;
        tag_q[g] <= '0;
        pfn_q[g] <= '0;
      end else if (flush_i) begin
        vld_q[g] <= 1'b0;  // flush beats any same-cycle fill
      end else if (sel) begin
        vld_q[g] <= wvld_i;
        rd_q[g]  <= wrd_i;
        wr_q[g]  <= wwr_i;
        tag_q[g] <= wtag_i;
        pfn_q[g] <= wpfn_i;
      end
    end
  end

  assign rtag_o = tag_q[ridx_i];
  assign rpfn_o = pfn_q[ridx_i];
  assign rvld_o = vld_q[ridx_i];
  assign rrd_o  = rd_q[ridx_i];
  assign rwr_o  = wr_q[ridx_i];
endmodule

// File: rtl/xtlb_check.sv
module xtlb_check #(
  parameter int unsigned TAG_W = 17
) (
  input  logic              wr_i,
  input  logic [TAG_W-1:0]  va_tag_i,
  input  logic [TAG_W-1:0]  ent_tag_i,
  input  logic              ent_vld_i,
  input  logic              ent_rd_i,
  input  logic              ent_wr_i,
  output xtlb_pkg::flt_e    fault_o
);
  import xtlb_pkg::*;

  always_comb begin
    if (!ent_vld_i || (va_tag_i != ent_tag_i)) fault_o = FLT_MISS;  // miss first
    else if (!wr_i && !ent_rd_i)              fault_o = FLT_RD;
    else if (wr_i && !ent_wr_i)               fault_o = FLT_WR;
    else                                      fault_o = FLT_NONE;
  end
endmodule

// File: rtl/xlat_tlb.sv
module xlat_tlb #(
  parameter int unsigned VA_W      = 32,
  parameter int unsigned PA_W      = 32,
  parameter int unsigned PAGE_BITS = 12,
  parameter int unsigned ENTRIES   = 8,
  localparam int unsigned IDX_W    = $clog2(ENTRIES),
  localparam int unsigned VPN_W    = VA_W - PAGE_BITS,
  localparam int unsigned TAG_W    = VPN_W - IDX_W,
  localparam int unsigned PFN_W    = PA_W - PAGE_BITS
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [VA_W-1:0]  lk_va_i,
  input  logic             lk_wr_i,
  output logic [PA_W-1:0]  lk_pa_o,
  output logic             lk_hit_o,
  output logic [1:0]       lk_fault_o,
  input  logic             fill_en_i,
  input  logic [VPN_W-1:0] fill_vpn_i,
  input  logic [PFN_W-1:0] fill_pfn_i,
  input  logic             fill_vld_i,
  input  logic             fill_rd_i,
  input  logic             fill_wr_i,
  input  logic             flush_i
);
  import xtlb_pkg::*;

  logic [IDX_W-1:0] lk_idx;
  logic [TAG_W-1:0] lk_tag;
  logic [TAG_W-1:0] e_tag;
  logic [PFN_W-1:0] e_pfn;
  logic             e_vld, e_rd, e_wr;
  flt_e             flt;

  assign lk_idx = lk_va_i[PAGE_BITS +: IDX_W];
  assign lk_tag = lk_va_i[VA_W-1 -: TAG_W];

  xtlb_store #(.ENTRIES(ENTRIES), .TAG_W(TAG_W), .PFN_W(PFN_W)) u_store (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .flush_i(flush_i),
    .wen_i  (fill_en_i),
    .widx_i (fill_vpn_i[IDX_W-1:0]),
    .wtag_i (fill_vpn_i[VPN_W-1 -: TAG_W]),
    .wpfn_i (fill_pfn_i),
    .wvld_i (fill_vld_i),
    .wrd_i  (fill_rd_i),
    .wwr_i  (fill_wr_i),
    .ridx_i (lk_idx),
    .rtag_o (e_tag),
    .rpfn_o (e_pfn),
    .rvld_o (e_vld),
    .rrd_o  (e_rd),
    .rwr_o  (e_wr)
  );

  xtlb_check #(.TAG_W(TAG_W)) u_check (
    .wr_i     (lk_wr_i),
    .va_tag_i (lk_tag),
    .ent_tag_i(e_tag),
    .ent_vld_i(e_vld),
    .ent_rd_i (e_rd),
    .ent_wr_i (e_wr),
    .fault_o  (flt)
  );

  assign lk_fault_o = flt;
  assign lk_hit_o   = (flt == FLT_NONE);
  assign lk_pa_o    = lk_hit_o ? {e_pfn, lk_va_i[PAGE_BITS-1:0]} : '0;
endmodule

// File: rtl/xlat_tlb_chk.sv
module xlat_tlb_chk #(
  parameter int unsigned VA_W      = 32,
  parameter int unsigned PA_W      = 32,
  parameter int unsigned PAGE_BITS = 12,
  localparam int unsigned VPN_W    = VA_W - PAGE_BITS,
  localparam int unsigned PFN_W    = PA_W - PAGE_BITS
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic [VA_W-1:0]  lk_va_i,
  input logic             lk_wr_i,
  input logic [PA_W-1:0]  lk_pa_o,
  input logic             lk_hit_o,
  input logic [1:0]       lk_fault_o,
  input logic             fill_en_i,
  input logic [VPN_W-1:0] fill_vpn_i,
  input logic [PFN_W-1:0] fill_pfn_i,
  input logic             fill_vld_i,
  input logic             fill_rd_i,
  input logic             fill_wr_i,
  input logic             flush_i
);
  // R9
  flush_clears_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    flush_i |=> (lk_fault_o == 2'b01));

  // R11
  fault_zero_pa_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (lk_fault_o != 2'b00) |-> (!lk_hit_o && lk_pa_o == '0));

  // R3
  offset_pass_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    lk_hit_o |-> (lk_pa_o[PAGE_BITS-1:0] == lk_va_i[PAGE_BITS-1:0]));

  // R5
  rd_fault_kind_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (lk_fault_o == 2'b10) |-> !lk_wr_i);

  // R6
  wr_fault_kind_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (lk_fault_o == 2'b11) |-> lk_wr_i);

  // R8
  fill_visible_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($past(fill_en_i && fill_vld_i && !flush_i) &&
     (lk_va_i[VA_W-1:PAGE_BITS] == $past(fill_vpn_i)) &&
     (lk_wr_i ? $past(fill_wr_i) : $past(fill_rd_i)))
    |-> (lk_hit_o && lk_pa_o[PA_W-1:PAGE_BITS] == $past(fill_pfn_i)));
endmodule

bind xlat_tlb xlat_tlb_chk #(.VA_W(VA_W), .PA_W(PA_W), .PAGE_BITS(PAGE_BITS)) u_chk (.*);

// File: tb/xlat_tlb_bench.sv
module xlat_tlb_bench;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic [31:0] lk_va_i = '0;
  logic        lk_wr_i = 1'b0;
  logic [31:0] lk_pa_o;
  logic        lk_hit_o;
  logic [1:0]  lk_fault_o;
  logic        fill_en_i = 1'b0;
  logic [19:0] fill_vpn_i = '0;
  logic [19:0] fill_pfn_i = '0;
  logic        fill_vld_i = 1'b0;
  logic        fill_rd_i = 1'b0;
  logic        fill_wr_i = 1'b0;
  logic        flush_i = 1'b0;

  int total = 0;
  int bad = 0;

  // reference model
  logic [16:0] m_tag [8];
  logic [19:0] m_pfn [8];
  logic [7:0]  m_v = '0, m_r = '0, m_w = '0;

  always #4 clk_i = ~clk_i;

  xlat_tlb u_xlat_tlb (.*);

  task automatic probe(input logic [31:0] va, input logic wr, input string req);
    logic [2:0]  ix;
    logic [1:0]  ef;
    logic [31:0] ep;
    ix = va[14:12];
    if (!m_v[ix] || m_tag[ix] != va[31:15]) ef = 2'b01;
    else if (!wr && !m_r[ix])              ef = 2'b10;
    else if (wr && !m_w[ix])               ef = 2'b11;
    else                                   ef = 2'b00;
    ep = (ef == 2'b00) ? {m_pfn[ix], va[11:0]} : 32'h0;
    @(negedge clk_i);
    lk_va_i = va;
    lk_wr_i = wr;
    #1;
    total++;
    if (lk_fault_o !== ef || lk_pa_o !== ep || lk_hit_o !== (ef == 2'b00)) begin
      bad++;
      $display("FAIL %s va=%h wr=%0d: fault=%b pa=%h hit=%b, expected fault=%b pa=%h hit=%b",
               req, va, wr, lk_fault_o, lk_pa_o, lk_hit_o, ef, ep, ef == 2'b00);
    end
  endtask

  task automatic fill(input logic [19:0] vpn, input logic [19:0] pfn,
                      input logic v, input logic r, input logic w, input logic fl);
    @(negedge clk_i);
    fill_en_i = 1'b1; fill_vpn_i = vpn; fill_pfn_i = pfn;
    fill_vld_i = v; fill_rd_i = r; fill_wr_i = w; flush_i = fl;
    @(negedge clk_i);
    fill_en_i = 1'b0; flush_i = 1'b0;
    if (fl) m_v = '0;
    else begin
      m_v[vpn[2:0]] = v; m_r[vpn[2:0]] = r; m_w[vpn[2:0]] = w;
      m_tag[vpn[2:0]] = vpn[19:3]; m_pfn[vpn[2:0]] = pfn;
    end
  endtask

  function automatic logic [16:0] tag_of(int i);
    return 17'h0A5C3 ^ 17'(i * 17'h1111);
  endfunction

  function automatic string req_of(logic [31:0] va, logic wr);
    logic [2:0] ix;
    ix = va[14:12];
    if (!m_v[ix])               return "R7/R4";
    if (m_tag[ix] != va[31:15]) return "R2/R4";
    if (!wr && !m_r[ix])        return "R5";
    if (wr && !m_w[ix])         return "R6";
    return "R3";
  endfunction

  initial begin : watchdog
    #800000;
    total++; bad++;
    $display("FAIL watchdog expired");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    for (int i = 0; i < 8; i++) begin m_tag[i] = '0; m_pfn[i] = '0; end
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;

    // R1: all slots absent after reset
    for (int i = 0; i < 8; i++) begin
      probe({15'h0, 3'(i), 12'h000}, 1'b0, "R1");
      probe({15'h0, 3'(i), 12'h000}, 1'b1, "R1");
    end

    // R8/R2: fill every slot, flags cycle through all four combinations
    for (int i = 0; i < 8; i++)
      fill({tag_of(i), 3'(i)}, 20'h80000 + 20'(i * 20'h01357), 1'b1, i[0], i[1], 1'b0);

    // R3 R4 R5 R6 R11 sweep: matching and mismatching tags, both access kinds, offsets
    for (int i = 0; i < 8; i++)
      for (int k = 0; k < 4; k++)
        for (int wr = 0; wr < 2; wr++) begin
          logic [31:0] va;
          va = {tag_of(i), 3'(i), 12'(k * 12'h555)};
          probe(va, wr[0], req_of(va, wr[0]));
          va = {tag_of(i) ^ 17'(1 << (k * 4)), 3'(i), 12'(k * 12'h3A1)};
          probe(va, wr[0], req_of(va, wr[0]));
        end

    // R7: absent slot carrying both permission flags still misses
    fill({tag_of(3), 3'd3}, 20'h12345, 1'b0, 1'b1, 1'b1, 1'b0);
    probe({tag_of(3), 3'd3, 12'hABC}, 1'b0, "R7");
    probe({tag_of(3), 3'd3, 12'hABC}, 1'b1, "R7");

    // R8: overwrite a slot with a new tag; old tag misses, new tag hits
    fill({tag_of(5) ^ 17'h1, 3'd5}, 20'hFEDCB, 1'b1, 1'b1, 1'b1, 1'b0);
    probe({tag_of(5), 3'd5, 12'h010}, 1'b0, "R8");
    probe({tag_of(5) ^ 17'h1, 3'd5, 12'hFFF}, 1'b1, "R8");

    // R9: one flush pulse clears every slot
    fill(20'h0, 20'h0, 1'b0, 1'b0, 1'b0, 1'b1);
    for (int i = 0; i < 8; i++) begin
      probe({tag_of(i), 3'(i), 12'h777}, 1'b0, "R9");
      probe({tag_of(i), 3'(i), 12'h777}, 1'b1, "R9");
    end

    // R10: fill in the same cycle as flush has no effect
    fill({tag_of(2), 3'd2}, 20'h0BEEF, 1'b1, 1'b1, 1'b1, 1'b1);
    probe({tag_of(2), 3'd2, 12'h123}, 1'b0, "R10");
    probe({tag_of(2), 3'd2, 12'h123}, 1'b1, "R10");

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule